// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block generates the control strobes that an 8-bit microcontroller core needs when it reaches code or data in memory outside the chip. It produces an address strobe (active high), a code-read strobe (active low) and the value driven onto the high-address port. Every machine cycle it looks at the kind of bus cycle the core asks for, the address, the port latch value and the execution mode. From these it plays a fixed strobe pattern across the next machine cycle.

A machine cycle lasts twelve oscillator clocks. These are organised as six states of two phases each, so the internal timing is a divide-by-two of the incoming clock and does not depend on its duty cycle. External data accesses suppress part of the normal pattern. A control bit can silence the address strobe on plain code fetches, but only while code runs from internal memory. An external-code strap picks the execution mode. When the lock input is set, the strap value captured during reset is used in place of the live pin.

Top module: `xbus_sequencer`

## Requirements
- R1: While reset is high, and through the whole first machine cycle after reset is released, the address strobe is 0, the code-read strobe is 1 and the high-address port is 8'hFF.
- R2: A machine cycle is 12 clocks, numbered tick 0 to 11. All inputs are sampled on the last clock of a cycle and govern the whole next cycle. The high-address port changes only when a new cycle starts (tick 0) and holds for all 12 ticks.
- R3: In a code fetch (bus_kind_i = 0) or a code-table read (bus_kind_i = 1), the address strobe gives two pulses per cycle. Each pulse is two clocks high, at ticks 1-2 and 7-8.
- R4: In an external data cycle (bus_kind_i = 2 for a 16-bit address, 3 for an 8-bit address), the second address-strobe pulse (ticks 7-8) is left out and only the tick 1-2 pulse appears.
- R5: In external execution, code fetches and code-table reads drive the code-read strobe low twice per cycle, at ticks 3-5 and 9-11. It is never low while the address strobe is high.
- R6: The code-read strobe stays high for a whole cycle when that cycle is an external data cycle, or when execution is internal.
- R7: With as_off_i = 1 and internal execution, a code fetch cycle gives no address-strobe pulse. Code-table reads and data cycles keep their normal pulses.
- R8: With external execution, as_off_i has no effect on the address strobe.
- R9: hi_addr_o carries addr_i[15:8] for external-execution code fetches and code-table reads and for 16-bit-address data cycles. It carries p2_latch_i for 8-bit-address data cycles and for code cycles under internal execution.
- R10: ext_code_n_i = 0 selects external execution. With lock1_i = 1, the strap value present during reset is used instead of the live pin. With lock1_i = 0, the live pin is used in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_kind_i | input | 2 | Cycle kind: 0 fetch, 1 code-table read, 2 data 16-bit addr, 3 data 8-bit addr |
| ext_code_n_i | input | 1 | External-code strap, low selects external execution |
| lock1_i | input | 1 | Lock bit 1 programmed: use strap value latched at reset |
| as_off_i | input | 1 | Address-strobe disable control bit |
| addr_i | input | 16 | Bus address from the core |
| p2_latch_i | input | 8 | Contents of the high port's output latch |
| addr_strobe_o | output | 1 | Address latch strobe, active high |
| code_rd_n_o | output | 1 | Code memory read strobe, active low |
| hi_addr_o | output | 8 | Value driven on the high-address port |

## Verification
Directed cycles walk each of the four cycle kinds under internal and external execution, with the disable bit set and clear. Comparing the tick masks of the two strobes separates the fetch pattern from the data-cycle pattern and shows whether the disable bit is honoured or ignored. A reset with the strap low and the lock set, followed by cycles with the strap pin driven high, tells a latched strap apart from a followed one. Random cycle sequences with varying address and latch bytes then show whether the high port selects the address byte or the latch for each addressing mode.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int PHASES_PER_STATE = 2;
    localparam int STATES_PER_CYCLE = 6;
    localparam int TICKS_PER_CYCLE  = PHASES_PER_STATE * STATES_PER_CYCLE;
    localparam int STROBE_SLOTS     = 2;
    localparam int AS_FIRST         = 1;
    localparam int AS_LEN           = 2;
    localparam int RD_FIRST         = 3;
    localparam int RD_LEN           = 3;
    localparam int ADDR_W           = 16;
    localparam int BYTE_W           = 8;

    typedef enum logic [1:0] {
        KIND_FETCH   = 2'd0,
        KIND_TABLE   = 2'd1,
        KIND_XDATA16 = 2'd2,
        KIND_XDATA8  = 2'd3
    } bus_kind_e;

    typedef struct packed {
        logic              valid;
        bus_kind_e         kind;
        logic              ext;
        logic              as_off;
        logic [BYTE_W-1:0] hi_addr;
        logic [BYTE_W-1:0] latch;
    } cyc_desc_t;

    function automatic logic is_xdata(input bus_kind_e k);
        return (k == KIND_XDATA16) || (k == KIND_XDATA8);
    endfunction

    function automatic logic is_code(input bus_kind_e k);
        return (k == KIND_FETCH) || (k == KIND_TABLE);
    endfunction

    function automatic logic tick_in(input int t, input int first, input int len);
        return (t >= first) && (t < first + len);
    endfunction

    function automatic logic as_slot_on(input cyc_desc_t d, input logic last_slot);
        logic gated;
        gated = d.as_off && !d.ext && (d.kind == KIND_FETCH);
        return d.valid && !(is_xdata(d.kind) && last_slot) && !gated;
    endfunction

    function automatic logic rd_slot_on(input cyc_desc_t d);
        return d.valid && d.ext && is_code(d.kind);
    endfunction

    function automatic logic [BYTE_W-1:0] hi_select(input cyc_desc_t d);
        logic [BYTE_W-1:0] v;
        if (!d.valid)                  v = '1;
        else if (d.kind == KIND_XDATA8)  v = d.latch;
        else if (d.kind == KIND_XDATA16) v = d.hi_addr;
        else if (d.ext)                v = d.hi_addr;
        else                           v = d.latch;
        return v;
    endfunction

endpackage

// File: rtl/xbus_timebase.sv
module xbus_timebase #(
    parameter int STATES = xbus_pkg::STATES_PER_CYCLE,
    parameter int PHASES = xbus_pkg::PHASES_PER_STATE,
    localparam int TICKS = STATES * PHASES,
    localparam int TW    = $clog2(TICKS)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    output logic [TW-1:0] tick_next_o,
    output logic          wrap_o
);

    logic [TW-1:0] tick_q;

    assign wrap_o = (tick_q == TW'(TICKS - 1));

    always_comb begin
        if (rst_i || wrap_o) tick_next_o = '0;
        else                 tick_next_o = tick_q + TW'(1);
    end

    always_ff @(posedge clk_i) begin
        tick_q <= tick_next_o;
    end

    AST_TICK_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_q < TW'(TICKS)); // R2
    AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_q != '0) |-> (tick_q == $past(tick_q) + TW'(1))); // R2

endmodule

// File: rtl/xbus_mode_latch.sv
module xbus_mode_latch (
    input  logic clk_i,
    input  logic rst_i,
    input  logic ext_code_n_i,
    input  logic lock1_i,
    output logic ext_exec_o
);

    logic strap_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) strap_q <= ext_code_n_i;
    end

    assign ext_exec_o = lock1_i ? ~strap_q : ~ext_code_n_i;

    AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (lock1_i && $past(lock1_i) && !$past(rst_i)) |-> $stable(ext_exec_o)); // R10

endmodule

// File: rtl/xbus_cycle_reg.sv
module xbus_cycle_reg
    import xbus_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wrap_i,
    input  bus_kind_e         kind_i,
    input  logic              ext_i,
    input  logic              as_off_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [BYTE_W-1:0] latch_i,
    output cyc_desc_t         desc_next_o
);

    cyc_desc_t desc_q;

    always_comb begin
        desc_next_o = desc_q;
        if (rst_i) begin
            desc_next_o = '0;
        end else if (wrap_i) begin
            desc_next_o.valid   = 1'b1;
            desc_next_o.kind    = kind_i;
            desc_next_o.ext     = ext_i;
            desc_next_o.as_off  = as_off_i;
            desc_next_o.hi_addr = addr_i[AW-1 -: BYTE_W];
            desc_next_o.latch   = latch_i;
        end
    end

    always_ff @(posedge clk_i) begin
        desc_q <= desc_next_o;
    end

    AST_DESC_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(wrap_i) && !$past(rst_i)) |-> $stable(desc_q)); // R2

endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
    import xbus_pkg::*;
#(
    parameter int TICKS    = TICKS_PER_CYCLE,
    parameter int SLOTS    = STROBE_SLOTS,
    parameter int AS_START = AS_FIRST,
    parameter int AS_WIDTH = AS_LEN,
    parameter int RD_START = RD_FIRST,
    parameter int RD_WIDTH = RD_LEN,
    localparam int TW       = $clog2(TICKS),
    localparam int SLOT_LEN = TICKS / SLOTS
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [TW-1:0]     tick_next_i,
    input  cyc_desc_t         desc_next_i,
    output logic              addr_strobe_o,
    output logic              code_rd_n_o,
    output logic [BYTE_W-1:0] hi_addr_o
);

    logic [SLOTS-1:0] as_hit;
    logic [SLOTS-1:0] rd_hit;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        localparam int BASE = g * SLOT_LEN;
        localparam logic LAST = (g == SLOTS - 1);
        assign as_hit[g] = as_slot_on(desc_next_i, LAST)
                        && tick_in(int'(tick_next_i), BASE + AS_START, AS_WIDTH);
        assign rd_hit[g] = rd_slot_on(desc_next_i)
                        && tick_in(int'(tick_next_i), BASE + RD_START, RD_WIDTH);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            addr_strobe_o <= 1'b0;
            code_rd_n_o   <= 1'b1;
            hi_addr_o     <= '1;
        end else begin
            addr_strobe_o <= |as_hit;
            code_rd_n_o   <= ~(|rd_hit);
            hi_addr_o     <= hi_select(desc_next_i);
        end
    end

    AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (rst_i)
        !(addr_strobe_o && !code_rd_n_o)); // R5
    AST_AS_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(addr_strobe_o) |-> $past(addr_strobe_o, 2)); // R3
    AST_RD_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(code_rd_n_o) |-> !$past(code_rd_n_o, 3)); // R5
    AST_HI_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (($past(tick_next_i) != '0) && !$past(rst_i)) |-> $stable(hi_addr_o)); // R2
    AST_XDATA_NO_RD: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(desc_next_i.valid) && $past(is_xdata(desc_next_i.kind))) |-> code_rd_n_o); // R6

endmodule

// File: rtl/xbus_sequencer.sv
module xbus_sequencer
    import xbus_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [1:0]        bus_kind_i,
    input  logic              ext_code_n_i,
    input  logic              lock1_i,
    input  logic              as_off_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] p2_latch_i,
    output logic              addr_strobe_o,
    output logic              code_rd_n_o,
    output logic [BYTE_W-1:0] hi_addr_o
);

    localparam int TW = $clog2(TICKS_PER_CYCLE);

    logic [TW-1:0] tick_next;
    logic          wrap;
    logic          ext_exec;
    cyc_desc_t     desc_next;

    xbus_timebase #(
        .STATES (STATES_PER_CYCLE),
        .PHASES (PHASES_PER_STATE)
    ) u_timebase (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .tick_next_o (tick_next),
        .wrap_o      (wrap)
    );

    xbus_mode_latch u_mode (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .ext_code_n_i (ext_code_n_i),
        .lock1_i      (lock1_i),
        .ext_exec_o   (ext_exec)
    );

    xbus_cycle_reg #(
        .AW (ADDR_W)
    ) u_cycle (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .wrap_i      (wrap),
        .kind_i      (bus_kind_e'(bus_kind_i)),
        .ext_i       (ext_exec),
        .as_off_i    (as_off_i),
        .addr_i      (addr_i),
        .latch_i     (p2_latch_i),
        .desc_next_o (desc_next)
    );

    xbus_strobe_gen #(
        .TICKS    (TICKS_PER_CYCLE),
        .SLOTS    (STROBE_SLOTS),
        .AS_START (AS_FIRST),
        .AS_WIDTH (AS_LEN),
        .RD_START (RD_FIRST),
        .RD_WIDTH (RD_LEN)
    ) u_strobe (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .tick_next_i   (tick_next),
        .desc_next_i   (desc_next),
        .addr_strobe_o (addr_strobe_o),
        .code_rd_n_o   (code_rd_n_o),
        .hi_addr_o     (hi_addr_o)
    );

endmodule

// File: tb/xbus_sequencer_tb.sv
module xbus_sequencer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  kind = 2'd0;
    logic        strap = 1'b1;
    logic        lock = 1'b0;
    logic        off = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  latch = 8'h00;
    logic        as_o;
    logic        rd_n_o;
    logic [7:0]  hi_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // previous-cycle inputs (their effect is observed in the current cycle)
    logic [1:0]  p_kind;
    logic        p_ext;
    logic        p_off;
    logic [15:0] p_addr;
    logic [7:0]  p_latch;
    string       p_tag;
    logic        strap_rst;

    // 50 MHz: 20 time units per period
    always #10 clk = ~clk;

    xbus_sequencer u_dut (
        .clk_i         (clk),
        .rst_i         (rst),
        .bus_kind_i    (kind),
        .ext_code_n_i  (strap),
        .lock1_i       (lock),
        .as_off_i      (off),
        .addr_i        (addr),
        .p2_latch_i    (latch),
        .addr_strobe_o (as_o),
        .code_rd_n_o   (rd_n_o),
        .hi_addr_o     (hi_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic model_ext(input logic l, input logic s);
        return l ? ~strap_rst : ~s;
    endfunction

    function automatic logic [11:0] exp_as_mask(input logic [1:0] k, input logic e, input logic o);
        logic on0;
        logic on1;
        on0 = !(o && !e && k == 2'd0);
        on1 = on0 && (k < 2'd2);
        return (on0 ? 12'h006 : 12'h000) | (on1 ? 12'h180 : 12'h000);
    endfunction

    function automatic logic [11:0] exp_rd_low_mask(input logic [1:0] k, input logic e);
        return (e && k < 2'd2) ? 12'hE38 : 12'h000;
    endfunction

    function automatic logic [7:0] exp_hi(input logic [1:0] k, input logic e,
                                          input logic [15:0] a, input logic [7:0] l);
        if (k == 2'd3) return l;
        if (k == 2'd2) return a[15:8];
        return e ? a[15:8] : l;
    endfunction

    function automatic string as_tag(input logic [1:0] k, input logic e, input logic o);
        if (k >= 2'd2) return "R4";
        if (o && !e)   return "R7";
        if (o && e)    return "R8";
        return "R3";
    endfunction

    function automatic string rd_tag(input logic [1:0] k, input logic e);
        return (k >= 2'd2 || !e) ? "R6" : "R5";
    endfunction

    task automatic set_inputs(input logic [1:0] k, input logic [15:0] a, input logic [7:0] l,
                              input logic s, input logic lk, input logic o);
        kind = k; addr = a; latch = l; strap = s; lock = lk; off = o;
    endtask

    task automatic remember(input string tag);
        p_kind = kind; p_addr = addr; p_latch = latch; p_off = off;
        p_ext = model_ext(lock, strap); p_tag = tag;
    endtask

    // reset, then walk through the idle first cycle; ends at tick 0 of cycle 1
    task automatic do_reset(input logic s, input logic lk);
        strap = s; lock = lk;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        strap_rst = s;
        @(negedge clk);
        chk(as_o == 1'b0 && rd_n_o == 1'b1 && hi_o == 8'hFF, "R1", "reset outputs",
            {as_o, rd_n_o, hi_o}, {1'b0, 1'b1, 8'hFF});
        rst = 1'b0;
        remember("");
        begin
            bit idle_ok = 1'b1;
            for (int i = 1; i < 12; i++) begin
                @(negedge clk);
                if (as_o !== 1'b0 || rd_n_o !== 1'b1 || hi_o !== 8'hFF) idle_ok = 1'b0;
            end
            chk(idle_ok, "R1", "first cycle idle", idle_ok, 1);
        end
        @(negedge clk);
    endtask

    // called at tick 0 of a cycle; drives the next cycle's inputs and checks this one
    task automatic do_cycle(input logic [1:0] k, input logic [15:0] a, input logic [7:0] l,
                            input logic s, input logic lk, input logic o, input string tag);
        logic [11:0] as_mask;
        logic [11:0] rd_mask;
        logic [7:0]  hi_first;
        bit          hi_same;
        int          as_cnt;
        int          rd_cnt;
        logic        prev_as;
        logic        prev_rd;
        string       ta;
        string       tr;
        set_inputs(k, a, l, s, lk, o);
        as_mask = '0; rd_mask = '0; hi_same = 1'b1; as_cnt = 0; rd_cnt = 0;
        prev_as = 1'b0; prev_rd = 1'b1;
        hi_first = hi_o;
        for (int i = 0; i < 12; i++) begin
            as_mask[i] = as_o;
            rd_mask[i] = ~rd_n_o;
            if (as_o && !prev_as) as_cnt++;
            if (!rd_n_o && prev_rd) rd_cnt++;
            prev_as = as_o;
            prev_rd = rd_n_o;
            if (hi_o !== hi_first) hi_same = 1'b0;
            @(negedge clk);
        end
        ta = (p_tag != "") ? p_tag : as_tag(p_kind, p_ext, p_off);
        tr = (p_tag != "") ? p_tag : rd_tag(p_kind, p_ext);
        chk(as_mask == exp_as_mask(p_kind, p_ext, p_off), ta, "addr strobe tick mask",
            as_mask, exp_as_mask(p_kind, p_ext, p_off));
        chk(as_cnt == $countones(exp_as_mask(p_kind, p_ext, p_off)) / 2, ta,
            "addr strobe pulse count", as_cnt,
            $countones(exp_as_mask(p_kind, p_ext, p_off)) / 2);
        chk(rd_mask == exp_rd_low_mask(p_kind, p_ext), tr, "code read low mask",
            rd_mask, exp_rd_low_mask(p_kind, p_ext));
        chk(rd_cnt == $countones(exp_rd_low_mask(p_kind, p_ext)) / 3, tr,
            "code read pulse count", rd_cnt, $countones(exp_rd_low_mask(p_kind, p_ext)) / 3);
        chk(hi_same, "R2", "high port steady over cycle", hi_same, 1);
        chk(hi_first == exp_hi(p_kind, p_ext, p_addr, p_latch),
            (p_tag != "") ? p_tag : "R9", "high port value",
            hi_first, exp_hi(p_kind, p_ext, p_addr, p_latch));
        remember(tag);
    endtask

    initial begin
        void'($urandom(32'h0051_7A3E));
        do_reset(1'b1, 1'b0);

        // directed: internal execution, disable clear
        do_cycle(2'd0, 16'h12AB, 8'h5C, 1'b1, 1'b0, 1'b0, "");
        do_cycle(2'd1, 16'h34CD, 8'h6D, 1'b1, 1'b0, 1'b0, "");
        do_cycle(2'd2, 16'h56EF, 8'h7E, 1'b1, 1'b0, 1'b0, "");
        do_cycle(2'd3, 16'h7801, 8'h8F, 1'b1, 1'b0, 1'b0, "");
        // external execution (strap low), disable clear
        do_cycle(2'd0, 16'hFFFF, 8'h11, 1'b0, 1'b0, 1'b0, "");
        do_cycle(2'd1, 16'h0000, 8'h22, 1'b0, 1'b0, 1'b0, "");
        do_cycle(2'd2, 16'hA5A5, 8'h33, 1'b0, 1'b0, 1'b0, "");
        do_cycle(2'd3, 16'h5A5A, 8'h44, 1'b0, 1'b0, 1'b0, "");
        // disable set, internal execution (R7)
        do_cycle(2'd0, 16'h9001, 8'h55, 1'b1, 1'b0, 1'b1, "");
        do_cycle(2'd1, 16'h9102, 8'h66, 1'b1, 1'b0, 1'b1, "");
        do_cycle(2'd2, 16'h9203, 8'h77, 1'b1, 1'b0, 1'b1, "");
        do_cycle(2'd3, 16'h9304, 8'h88, 1'b1, 1'b0, 1'b1, "");
        // disable set, external execution: ignored (R8)
        do_cycle(2'd0, 16'hC0DE, 8'h99, 1'b0, 1'b0, 1'b1, "");
        do_cycle(2'd1, 16'hBEEF, 8'hAA, 1'b0, 1'b0, 1'b1, "");
        do_cycle(2'd0, 16'h1111, 8'hBB, 1'b1, 1'b0, 1'b0, "");

        // R10: lock set, strap low at reset, live pin later high -> still external
        do_reset(1'b0, 1'b1);
        do_cycle(2'd0, 16'h4321, 8'hCC, 1'b1, 1'b1, 1'b0, "R10");
        do_cycle(2'd1, 16'h8765, 8'hDD, 1'b1, 1'b1, 1'b1, "R10");
        // R10: lock clear, live pin followed each cycle
        do_cycle(2'd0, 16'h2468, 8'hEE, 1'b1, 1'b0, 1'b0, "R10");
        do_cycle(2'd0, 16'h1357, 8'h0F, 1'b0, 1'b0, 1'b0, "R10");
        do_cycle(2'd0, 16'h0F0F, 8'hF0, 1'b1, 1'b0, 1'b0, "");

        // constrained random cycles
        for (int n = 0; n < 300; n++) begin
            do_cycle(2'($urandom_range(3)), 16'($urandom), 8'($urandom),
                     1'($urandom_range(1)), ($urandom_range(3) == 0),
                     1'($urandom_range(1)), "");
        end
        // flush the last random cycle
        do_cycle(2'd0, 16'h0000, 8'h00, 1'b1, 1'b0, 1'b0, "");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule